// File: doc/BRIEF.md
# Reset strap identification responder

This block watches the chip reset and, on the clock edge where reset is first seen released, captures two board-level configuration straps. One strap selects the cache policy (write-through or write-back) and the other selects the core clock multiplier. Each strap comes as a level plus a "driven" flag, so a pin left open can be modelled: an open multiplier strap reads as high, like a pin with a pull-up, and an open cache strap reads as write-through. A static core-variant select picks which family member is being emulated: double-clock, triple-clock or high-speed core. A grade flag picks the speed grade of the high-speed core.

From the captured straps and the variant, the block builds three things. The first is a 16-bit identification word of the form 04Mx, where M is a model nibble that depends on both the variant and the captured cache policy. The second is a latched multiplier code. The third is a latched cache-policy flag. It also answers identification queries combinationally. Leaf 0 returns a twelve-character vendor string. Leaf 1 returns a version word carrying stepping, model and family, plus a flag word that shows a floating-point unit is present.

The stepping nibble and the vendor string are parameters. The instruction decoder that issues a query drives the leaf number and reads the four result registers in the same cycle.

Top module: `strap_ident`

## Requirements
- R1: Straps and variant inputs are captured on the first rising clock edge at which `rst` is low after having been high. They become visible on the outputs from that edge on, and later strap changes have no effect until the next reset.
- R2: Multiplier code encoding is 0 = 2x, 1 = 3x, 2 = 4x. An undriven strap (`mul_drv`=0) or a driven high level gives 3x. A driven low level gives 2x on the double-clock core (`core_sel`=0) and on the triple-clock core (`core_sel`=1), and 4x on the high-speed core (`core_sel`=2).
- R3: `cache_wb` is 1 only when the cache strap is driven high (`wbm_drv`=1, `wbm_lvl`=1). It is 0 when the strap is driven low or left undriven.
- R4: `rst_id_word` equals {8'h04, model, STEP}: family 4 in bits 11:8, zero in bits 15:12, and the stepping parameter in bits 3:0.
- R5: While `rst` is high, and on the edge that follows it, `rst_id_word`, `mult_code`, `cache_wb` and every query register read zero.
- R6: Model nibble, written as write-through/write-back: double-clock core 3/7; triple-clock core 8/9; high-speed core with `grade_150`=1 8/9; high-speed core with `grade_150`=0 E/F.
- R7: `core_sel`=3 behaves exactly as the triple-clock core. `grade_150` has no effect unless `core_sel`=2.
- R8: Leaf 0 returns EAX=1 (highest leaf). The 12-character vendor string is returned in the order EBX, EDX, ECX, four characters each, with the first character of each group in bits 7:0.
- R9: Leaf 1 returns EAX = {16'h0, 4'h0, 4'h4, model, STEP}, EBX=0, ECX=0 and EDX=1.
- R10: Any leaf other than 0 and 1 returns zero in all four registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release triggers the capture |
| mul_drv | input | 1 | Multiplier strap is driven (0 = open, reads high) |
| mul_lvl | input | 1 | Multiplier strap level when driven |
| wbm_drv | input | 1 | Cache strap is driven (0 = open, reads write-through) |
| wbm_lvl | input | 1 | Cache strap level when driven (1 = write-back) |
| core_sel | input | 2 | Core variant: 0 double-clock, 1 triple-clock, 2 high-speed, 3 as 1 |
| grade_150 | input | 1 | High-speed core speed grade: 1 = 150 MHz grade |
| leaf | input | 32 | Query leaf number |
| rst_id_word | output | 16 | Identification word 04Mx |
| mult_code | output | 2 | Latched multiplier code |
| cache_wb | output | 1 | Latched cache policy, 1 = write-back |
| q_eax | output | 32 | Query result A |
| q_ebx | output | 32 | Query result B |
| q_ecx | output | 32 | Query result C |
| q_edx | output | 32 | Query result D |

## Verification
On every cycle the assertions check four things: the outputs are cleared after any reset cycle, the captured state stays frozen once reset has been released, the family byte of the identification word is fixed, and unknown leaves read zero. They also check that the model nibble in the leaf-1 answer matches the one in the identification word. Only the bench scenarios can show that each strap and variant combination gives the right model and multiplier, including an open strap, the aliased variant and the grade flag on other cores. They also show that strap changes after release are ignored and that the vendor characters land in the right registers and byte lanes.

// File: rtl/strap_ident_pkg.sv
package strap_ident_pkg;

    localparam int FAMILY = 4;

    typedef enum logic [1:0] {
        MUL_2X = 2'd0,
        MUL_3X = 2'd1,
        MUL_4X = 2'd2
    } mult_e;

    typedef enum logic [1:0] {
        CORE_DBL  = 2'd0,
        CORE_TRI  = 2'd1,
        CORE_FAST = 2'd2,
        CORE_ALT  = 2'd3
    } core_e;

    typedef struct packed {
        logic       valid;
        logic       wb;
        mult_e      mult;
        logic [3:0] model;
    } strap_state_t;

    function automatic logic [3:0] model_of(input core_e core, input logic grade150,
                                            input logic wb);
        logic [3:0] base;
        case (core)
            CORE_DBL:  base = 4'h3;
            CORE_FAST: base = grade150 ? 4'h8 : 4'hE;
            default:   base = 4'h8;
        endcase
        if (core == CORE_DBL) return wb ? 4'h7 : base;
        return base | {3'b000, wb};
    endfunction

    function automatic mult_e mult_of(input core_e core, input logic strap_high);
        if (strap_high) return MUL_3X;
        return (core == CORE_FAST) ? MUL_4X : MUL_2X;
    endfunction

    function automatic logic [31:0] vendor_word(input logic [95:0] text, input int grp);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++) begin
            w[8*k +: 8] = text[95 - 8*(4*grp + k) -: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_ident_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         mul_drv,
    input  logic         mul_lvl,
    input  logic         wbm_drv,
    input  logic         wbm_lvl,
    input  logic [1:0]   core_sel,
    input  logic         grade_150,
    output strap_state_t state
);
    logic  rst_d;
    logic  mul_high;
    logic  wb_eff;
    core_e core;

    // open multiplier strap reads high; open cache strap reads write-through
    assign mul_high = mul_drv ? mul_lvl : 1'b1;
    assign wb_eff   = wbm_drv & wbm_lvl;
    assign core     = core_e'(core_sel);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            state <= '0;
        end else if (rst_d) begin
            state.valid <= 1'b1;
            state.wb    <= wb_eff;
            state.mult  <= mult_of(core, mul_high);
            state.model <= model_of(core, grade_150, wb_eff);
        end
    end

    // R1: after the capture edge the state is frozen until reset returns
    assert_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !rst_d |=> $stable(state));

endmodule

// File: rtl/id_word_gen.sv
module id_word_gen
    import strap_ident_pkg::*;
#(
    parameter logic [3:0] STEP = 4'h2
) (
    input  strap_state_t state,
    output logic [15:0]  id_word,
    output logic [31:0]  version
);
    localparam logic [3:0] FAM = 4'(FAMILY);

    always_comb begin
        id_word = '0;
        version = '0;
        if (state.valid) begin
            id_word = {4'h0, FAM, state.model, STEP};
            version = {16'h0, 4'h0, FAM, state.model, STEP};
        end
    end
endmodule

// File: rtl/leaf_responder.sv
module leaf_responder
    import strap_ident_pkg::*;
#(
    parameter int          LEAF_W = 32,
    parameter int          REG_W  = 32,
    parameter logic [95:0] VENDOR = "StrapIdBlock"
) (
    input  logic              valid,
    input  logic [LEAF_W-1:0] leaf,
    input  logic [31:0]       version,
    output logic [REG_W-1:0]  r_a,
    output logic [REG_W-1:0]  r_b,
    output logic [REG_W-1:0]  r_c,
    output logic [REG_W-1:0]  r_d
);
    localparam int NGRP = 3;
    localparam logic [LEAF_W-1:0] MAX_LEAF = LEAF_W'(1);

    logic [31:0] vend [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_vend
        assign vend[g] = vendor_word(VENDOR, g);
    end

    always_comb begin
        r_a = '0;
        r_b = '0;
        r_c = '0;
        r_d = '0;
        if (valid) begin
            if (leaf == '0) begin
                r_a = REG_W'(MAX_LEAF);
                r_b = REG_W'(vend[0]);
                r_d = REG_W'(vend[1]);
                r_c = REG_W'(vend[2]);
            end else if (leaf == MAX_LEAF) begin
                r_a = REG_W'(version);
                r_d = REG_W'(1);
            end
        end
    end
endmodule

// File: rtl/strap_ident.sv
module strap_ident
    import strap_ident_pkg::*;
#(
    parameter logic [3:0]  STEP   = 4'h2,
    parameter int          LEAF_W = 32,
    parameter int          REG_W  = 32,
    parameter logic [95:0] VENDOR = "StrapIdBlock"
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mul_drv,
    input  logic              mul_lvl,
    input  logic              wbm_drv,
    input  logic              wbm_lvl,
    input  logic [1:0]        core_sel,
    input  logic              grade_150,
    input  logic [LEAF_W-1:0] leaf,
    output logic [15:0]       rst_id_word,
    output logic [1:0]        mult_code,
    output logic              cache_wb,
    output logic [REG_W-1:0]  q_eax,
    output logic [REG_W-1:0]  q_ebx,
    output logic [REG_W-1:0]  q_ecx,
    output logic [REG_W-1:0]  q_edx
);
    strap_state_t st;
    logic [31:0]  version;

    strap_capture u_cap (
        .clk(clk), .rst(rst),
        .mul_drv(mul_drv), .mul_lvl(mul_lvl),
        .wbm_drv(wbm_drv), .wbm_lvl(wbm_lvl),
        .core_sel(core_sel), .grade_150(grade_150),
        .state(st)
    );

    id_word_gen #(.STEP(STEP)) u_word (
        .state(st), .id_word(rst_id_word), .version(version)
    );

    leaf_responder #(.LEAF_W(LEAF_W), .REG_W(REG_W), .VENDOR(VENDOR)) u_leaf (
        .valid(st.valid), .leaf(leaf), .version(version),
        .r_a(q_eax), .r_b(q_ebx), .r_c(q_ecx), .r_d(q_edx)
    );

    assign mult_code = st.mult;
    assign cache_wb  = st.wb;

    // R5: a reset cycle leaves every output cleared
    assert_cleared_R5: assert property (@(posedge clk)
        rst |=> (rst_id_word == 16'h0 && mult_code == 2'd0 && !cache_wb));

    // R4: family byte is constant once an identification is held
    assert_family_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_id_word != 16'h0) |-> (rst_id_word[15:8] == 8'h04));

    // R9: leaf-1 model agrees with the identification word
    assert_model_match_R9: assert property (@(posedge clk) disable iff (rst)
        (leaf == LEAF_W'(1) && rst_id_word != 16'h0) |->
        (q_eax[7:0] == rst_id_word[7:0] && q_edx == REG_W'(1)));

    // R10: unknown leaves read zero
    assert_unknown_leaf_R10: assert property (@(posedge clk) disable iff (rst)
        (leaf > LEAF_W'(1)) |->
        (q_eax == '0 && q_ebx == '0 && q_ecx == '0 && q_edx == '0));

endmodule

// File: tb/test_strap_ident.sv
module test_strap_ident;
    localparam logic [3:0] STEP = 4'h2;
    localparam string VS = "StrapIdBlock";

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mul_drv = 1'b0, mul_lvl = 1'b0, wbm_drv = 1'b0, wbm_lvl = 1'b0;
    logic [1:0]  core_sel = 2'd0;
    logic        grade_150 = 1'b0;
    logic [31:0] leaf = 32'd5;
    logic [15:0] rst_id_word;
    logic [1:0]  mult_code;
    logic        cache_wb;
    logic [31:0] q_eax, q_ebx, q_ecx, q_edx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    strap_ident i_strap_ident (
        .clk(clk), .rst(rst), .mul_drv(mul_drv), .mul_lvl(mul_lvl),
        .wbm_drv(wbm_drv), .wbm_lvl(wbm_lvl), .core_sel(core_sel),
        .grade_150(grade_150), .leaf(leaf), .rst_id_word(rst_id_word),
        .mult_code(mult_code), .cache_wb(cache_wb),
        .q_eax(q_eax), .q_ebx(q_ebx), .q_ecx(q_ecx), .q_edx(q_edx)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] exp_model(logic [1:0] c, logic g, logic wb);
        if (c == 2'd0) return wb ? 4'h7 : 4'h3;
        if (c == 2'd2 && !g) return wb ? 4'hF : 4'hE;
        return wb ? 4'h9 : 4'h8;
    endfunction

    function automatic logic [1:0] exp_mult(logic [1:0] c, logic drv, logic lvl);
        if (!drv || lvl) return 2'd1;
        return (c == 2'd2) ? 2'd2 : 2'd0;
    endfunction

    function automatic logic [31:0] exp_vend(int grp);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = VS[4*grp + k];
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply a reset with the given straps, release, return after capture edge
    task automatic boot(logic [1:0] c, logic g, logic md, logic ml, logic wd, logic wl);
        @(negedge clk);
        rst = 1'b1; core_sel = c; grade_150 = g;
        mul_drv = md; mul_lvl = ml; wbm_drv = wd; wbm_lvl = wl;
        repeat (2) @(negedge clk);
        leaf = 32'd1; #1;
        chk("R5 word in reset", {16'h0, rst_id_word}, 32'h0);
        chk("R5 query in reset", q_eax | q_edx, 32'h0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic verify(logic [1:0] c, logic g, logic md, logic ml, logic wd, logic wl);
        logic wb;
        logic [3:0] m;
        wb = wd & wl;
        m  = exp_model(c, g, wb);
        chk("R4 R6 R7 id word", {16'h0, rst_id_word}, {16'h0, 8'h04, m, STEP});
        chk("R2 mult", {30'h0, mult_code}, {30'h0, exp_mult(c, md, ml)});
        chk("R3 cache", {31'h0, cache_wb}, {31'h0, wb});
        leaf = 32'd1; #1;
        chk("R9 eax", q_eax, {16'h0, 8'h04, m, STEP});
        chk("R9 ebx|ecx", q_ebx | q_ecx, 32'h0);
        chk("R9 edx", q_edx, 32'h1);
    endtask

    initial begin
        logic [1:0] c;
        logic g, md, ml, wd, wl;
        void'($urandom(32'd4711));
        @(negedge clk);
        chk("R5 reset state", {14'h0, mult_code, cache_wb, rst_id_word[0]}, 32'h0);

        // directed corners: open straps, aliased core, grade on other cores
        boot(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); verify(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        boot(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); verify(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        boot(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); verify(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        boot(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); verify(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        boot(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); verify(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

        // R8 vendor leaf
        leaf = 32'd0; #1;
        chk("R8 eax", q_eax, 32'h1);
        chk("R8 ebx", q_ebx, exp_vend(0));
        chk("R8 edx", q_edx, exp_vend(1));
        chk("R8 ecx", q_ecx, exp_vend(2));

        for (int i = 0; i < 60; i++) begin
            c = 2'($urandom); g = 1'($urandom); md = 1'($urandom);
            ml = 1'($urandom); wd = 1'($urandom); wl = 1'($urandom);
            boot(c, g, md, ml, wd, wl);
            verify(c, g, md, ml, wd, wl);
            // R1: strap changes after release are ignored
            @(negedge clk);
            core_sel = ~c; grade_150 = ~g; mul_drv = 1'b1; mul_lvl = ~ml;
            wbm_drv = 1'b1; wbm_lvl = ~(wd & wl);
            repeat (3) @(negedge clk);
            chk("R1 held word", {16'h0, rst_id_word},
                {16'h0, 8'h04, exp_model(c, g, wd & wl), STEP});
            chk("R1 held mult", {30'h0, mult_code}, {30'h0, exp_mult(c, md, ml)});
            // R10 random leaf above 1
            leaf = $urandom | 32'h2; #1;
            chk("R10 unknown leaf", q_eax | q_ebx | q_ecx | q_edx, 32'h0);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule